// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

A first-in first-out buffer whose producer and consumer run on unrelated clocks. Words go in on `wr_clk` when `wr_en` is high and come out on `rd_clk` when `rd_en` is high. The read data path is registered, so a word appears on `rd_data` one `rd_clk` edge after the read. Each side reports its own view of the fill level. The write side drives full, half-full and almost-full flags. The read side drives empty and almost-empty flags. Full, empty, almost-full and almost-empty are all active low.

The two thresholds sit in a pair of offset registers. A master reset loads them from one of eight built-in pairs chosen by strap inputs. The same reset latches a strap that picks registered or direct flag timing. After reset, a bit-serial port clocked by `wr_clk` can overwrite both offsets. A partial reset empties the buffer and keeps the offsets and the timing mode.

Top module: `dcfifo_pflag`

## Requirements
- R1: A write with `wr_en` high and `full_n` high stores `wr_data`. A read with `rd_en` high and `empty_n` high puts the oldest stored word on `rd_data` at that `rd_clk` edge. Words come out in write order.
- R2: `empty_n` is low when the read side sees zero stored words. `full_n` is low when the write side sees DEPTH stored words (16 by default).
- R3: A write while `full_n` is low and a read while `empty_n` is low are both ignored. No pointer moves, no stored word changes, and `rd_data` holds its value.
- R4: `half_full` is high when the write-side word count is at least DEPTH/2+1 (9 by default), and low otherwise.
- R5: `aempty_n` is low when the read-side count is below the empty offset, and high when the count is at least the empty offset.
- R6: `afull_n` is high when the free space (DEPTH minus the write-side count) is greater than the full offset. It is low when the free space is less than or equal to the full offset.
- R7: During master reset, `preset_sel` (value k, 0 to 7) loads both offsets with min(k+1, DEPTH-1).
- R8: `strap_sync`, latched during master reset, selects the flag timing. When it is 0, `aempty_n` and `afull_n` change at the same edge that moves the local pointer. When it is 1, they change one clock of their own domain later.
- R9: While `load_n` and `shift_en_n` are both low, each `wr_clk` edge shifts in one bit of `shift_din`. The first log2(DEPTH) bits form the empty offset and the next log2(DEPTH) bits form the full offset, each sent LSB first. Both offsets take their new values at the last bit. An edge with only one of the two inputs low shifts nothing.
- R10: `prst` empties the FIFO and zeroes `rd_data`. It keeps the offsets and the timing mode.
- R11: `mrst` empties the FIFO and zeroes `rd_data`. After it, `empty_n` is low, `full_n` is high and `half_full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous, active high, held for several cycles of both clocks |
| prst | input | 1 | Partial reset, synchronous, active high, held for several cycles of both clocks |
| preset_sel | input | 3 | Default offset pair choice, sampled during master reset |
| strap_sync | input | 1 | Flag timing choice, sampled during master reset (1 = registered) |
| load_n | input | 1 | Serial load strobe, active low |
| shift_en_n | input | 1 | Serial shift enable, active low |
| shift_din | input | 1 | Serial offset data |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write word |
| full_n | output | 1 | Low when full |
| half_full | output | 1 | High above half depth |
| afull_n | output | 1 | Low when free space is at or below the full offset |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Registered read word |
| empty_n | output | 1 | Low when empty |
| aempty_n | output | 1 | Low when the count is below the empty offset |

## Verification
The bench walks the fill level through each flag threshold, one word at a time. A flag that is off by one word flips on the wrong side of the boundary. It also writes to a full FIFO and reads from an empty one. A design that moved a pointer on either access would return the wrong word on the next read, or would drop `full_n` back high. During a serial load, the bench inserts edges with only the enable low. A loader that counted those edges would finish early with shifted offsets, and the almost-empty and almost-full thresholds would land on the wrong counts. The bench also samples `afull_n` one instant after a write edge in both timing modes. A design that ignored the mode strap would show the same lag in both modes.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;

  typedef enum logic {
    FLAG_DIRECT = 1'b0,
    FLAG_REGD   = 1'b1
  } flag_mode_e;

  // Default offset for strap value sel: sel+1, capped at depth-1.
  function automatic int preset_offset(input int sel, input int depth);
    int v;
    v = sel + 1;
    if (v > depth - 1) v = depth - 1;
    return v;
  endfunction

endpackage

// File: rtl/pf_sync.sv
// Two-flop synchroniser for a Gray pointer; emits the binary value.
module pf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= gray_in;
      stab_q <= meta_q;
    end
  end

  always_comb begin
    logic [W-1:0] acc;
    acc[W-1] = stab_q[W-1];
    for (int i = W - 2; i >= 0; i--) acc[i] = acc[i+1] ^ stab_q[i];
    bin_out = acc;
  end
endmodule

// File: rtl/pf_mem.sv
// Simple dual-port storage with registered read, block-RAM friendly.
module pf_mem #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] store [WORDS];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/pf_wr_ctl.sv
// Write side: pointer, full/half/almost-full flags, offset registers, serial loader.
module pf_wr_ctl #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic [2:0]    preset_sel,
  input  logic          strap_sync,
  input  logic          load_n,
  input  logic          shift_en_n,
  input  logic          shift_din,
  input  logic          wr_en,
  input  logic [PW-1:0] rbin_s,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic          mem_we,
  output logic          full_n,
  output logic          half_full,
  output logic          afull_n,
  output logic [AW-1:0] ae_off,
  output fifo_pf_pkg::flag_mode_e mode
);
  import fifo_pf_pkg::*;

  localparam int LBITS = 2 * AW;
  localparam int CW    = $clog2(LBITS);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2 + 1);

  logic            rst_any;
  logic [PW-1:0]   wcount, free_cnt;
  logic            afull_now, afull_q;
  logic [AW-1:0]   af_off;
  logic [LBITS-1:0] shreg, shnext;
  logic [CW-1:0]   bitcnt;
  logic            shifting;

  assign rst_any  = mrst | prst;
  assign wcount   = wbin - rbin_s;
  assign free_cnt = FULL_CNT - wcount;

  assign full_n    = (wcount != FULL_CNT);
  assign half_full = (wcount >= HALF_CNT);
  assign afull_now = (free_cnt > {1'b0, af_off});
  assign afull_n   = (mode == FLAG_REGD) ? afull_q : afull_now;
  assign mem_we    = wr_en & full_n;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      wbin    <= '0;
      wgray   <= '0;
      afull_q <= 1'b1;
    end else begin
      afull_q <= afull_now;
      if (mem_we) begin
        wbin  <= wbin + 1'b1;
        wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
    end
  end

  // Serial offset loader: empty offset first, then full offset, LSB first.
  assign shifting = ~load_n & ~shift_en_n;
  assign shnext   = {shift_din, shreg[LBITS-1:1]};

  always_ff @(posedge clk) begin
    if (mrst) begin
      ae_off <= AW'(preset_offset(int'(preset_sel), DEPTH));
      af_off <= AW'(preset_offset(int'(preset_sel), DEPTH));
      mode   <= flag_mode_e'(strap_sync);
      shreg  <= '0;
      bitcnt <= '0;
    end else if (prst) begin
      shreg  <= '0;
      bitcnt <= '0;
    end else if (shifting) begin
      shreg <= shnext;
      if (bitcnt == CW'(LBITS - 1)) begin
        bitcnt <= '0;
        ae_off <= shnext[AW-1:0];
        af_off <= shnext[LBITS-1:AW];
      end else begin
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pf_rd_ctl.sv
// Read side: pointer, empty and almost-empty flags.
module pf_rd_ctl #(
  parameter int AW = 4,
  parameter int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [PW-1:0] wbin_s,
  input  logic [AW-1:0] ae_off,
  input  fifo_pf_pkg::flag_mode_e mode,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray,
  output logic          mem_re,
  output logic          empty_n,
  output logic          aempty_n
);
  import fifo_pf_pkg::*;

  logic [PW-1:0] rcount;
  logic          aempty_now, aempty_q;

  assign rcount     = wbin_s - rbin;
  assign empty_n    = (rcount != '0);
  assign aempty_now = (rcount >= {1'b0, ae_off});
  assign aempty_n   = (mode == FLAG_REGD) ? aempty_q : aempty_now;
  assign mem_re     = rd_en & empty_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin     <= '0;
      rgray    <= '0;
      aempty_q <= 1'b0;
    end else begin
      aempty_q <= aempty_now;
      if (mem_re) begin
        rbin  <= rbin + 1'b1;
        rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
      end
    end
  end
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int DEPTH = 16,
  parameter int DW    = 16
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic [2:0]    preset_sel,
  input  logic          strap_sync,
  input  logic          load_n,
  input  logic          shift_en_n,
  input  logic          shift_din,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full_n,
  output logic          half_full,
  output logic          afull_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] w_bin, w_gray, r_bin, r_gray, w_bin_s, r_bin_s;
  logic          rst_any, mem_we, mem_re;
  logic [AW-1:0] ae_off;
  fifo_pf_pkg::flag_mode_e mode;

  assign rst_any = mrst | prst;

  pf_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk(wr_clk), .mrst(mrst), .prst(prst), .preset_sel(preset_sel),
    .strap_sync(strap_sync), .load_n(load_n), .shift_en_n(shift_en_n),
    .shift_din(shift_din), .wr_en(wr_en), .rbin_s(r_bin_s),
    .wbin(w_bin), .wgray(w_gray), .mem_we(mem_we), .full_n(full_n),
    .half_full(half_full), .afull_n(afull_n), .ae_off(ae_off), .mode(mode)
  );

  pf_rd_ctl #(.AW(AW), .PW(PW)) u_rd (
    .clk(rd_clk), .rst(rst_any), .rd_en(rd_en), .wbin_s(w_bin_s),
    .ae_off(ae_off), .mode(mode), .rbin(r_bin), .rgray(r_gray),
    .mem_re(mem_re), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  pf_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst(rst_any), .gray_in(w_gray), .bin_out(w_bin_s)
  );

  pf_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst(rst_any), .gray_in(r_gray), .bin_out(r_bin_s)
  );

  pf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(mem_we), .waddr(w_bin[AW-1:0]), .wdata(wr_data),
    .rclk(rd_clk), .rrst(rst_any), .re(mem_re), .raddr(r_bin[AW-1:0]),
    .rdata(rd_data)
  );
endmodule

// File: rtl/dcfifo_pflag_chk.sv
module dcfifo_pflag_chk #(
  parameter int PW = 5,
  parameter int DW = 16
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          mrst,
  input logic          prst,
  input logic          wr_en,
  input logic          full_n,
  input logic          half_full,
  input logic [PW-1:0] w_bin,
  input logic          rd_en,
  input logic          empty_n,
  input logic [PW-1:0] r_bin,
  input logic [DW-1:0] rd_data
);
  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (mrst || prst)
    (wr_en && !full_n) |=> (w_bin == $past(w_bin)));

  assert_no_underflow_R3: assert property (@(posedge rd_clk) disable iff (mrst || prst)
    (rd_en && !empty_n) |=> ((r_bin == $past(r_bin)) && $stable(rd_data)));

  assert_write_advance_R1: assert property (@(posedge wr_clk) disable iff (mrst || prst)
    (wr_en && full_n) |=> (w_bin == $past(w_bin) + 1'b1));

  assert_full_above_half_R4: assert property (@(posedge wr_clk) disable iff (mrst || prst)
    !full_n |-> half_full);

  assert_prst_clears_R10: assert property (@(posedge rd_clk) disable iff (mrst)
    prst |=> ((r_bin == '0) && (rd_data == '0)));
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.PW(PW), .DW(DW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .prst(prst),
  .wr_en(wr_en), .full_n(full_n), .half_full(half_full), .w_bin(w_bin),
  .rd_en(rd_en), .empty_n(empty_n), .r_bin(r_bin), .rd_data(rd_data)
);

// File: tb/dcfifo_pflag_bench.sv
module dcfifo_pflag_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DW         = 16;

  logic wr_clk = 0, rd_clk = 0;
  logic mrst, prst, strap_sync, load_n, shift_en_n, shift_din, wr_en, rd_en;
  logic [2:0] preset_sel;
  logic [DW-1:0] wr_data, rd_data, got;
  logic full_n, half_full, afull_n, empty_n, aempty_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  dcfifo_pflag #(.DEPTH(16), .DW(DW)) u_dcfifo_pflag (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .prst(prst),
    .preset_sel(preset_sel), .strap_sync(strap_sync), .load_n(load_n),
    .shift_en_n(shift_en_n), .shift_din(shift_din), .wr_en(wr_en),
    .wr_data(wr_data), .full_n(full_n), .half_full(half_full),
    .afull_n(afull_n), .rd_en(rd_en), .rd_data(rd_data),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge rd_clk);
    repeat (2) @(posedge wr_clk);
    #1;
  endtask

  task automatic do_mrst(input logic [2:0] sel, input logic sync);
    @(negedge wr_clk);
    mrst = 1; preset_sel = sel; strap_sync = sync;
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk);
    mrst = 0;
    settle();
  endtask

  task automatic do_prst();
    @(negedge wr_clk);
    prst = 1;
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk);
    prst = 0;
    settle();
  endtask

  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1; wr_data = d;
    @(posedge wr_clk);
    #1 wr_en = 0;
  endtask

  task automatic rd_word(output logic [DW-1:0] d);
    @(negedge rd_clk);
    rd_en = 1;
    @(posedge rd_clk);
    #1 d = rd_data;
    rd_en = 0;
  endtask

  task automatic send_bit(input logic b, input logic only_sen);
    @(negedge wr_clk);
    shift_en_n = 0; load_n = only_sen; shift_din = b;
    @(posedge wr_clk);
    #1 shift_en_n = 1; load_n = 1;
  endtask

  // Offsets 3/3, direct timing.
  task automatic test_reset_state();
    check("R11 empty_n after mrst", empty_n, 0);
    check("R11 full_n after mrst", full_n, 1);
    check("R11 half_full after mrst", half_full, 0);
    check("R11 rd_data after mrst", rd_data, 0);
    check("R5 aempty_n at 0", aempty_n, 0);
    check("R6 afull_n at 0", afull_n, 1);
  endtask

  task automatic test_fill();
    for (int i = 1; i <= 16; i++) begin
      wr_word(16'hA000 + 16'(i));
      if (i == 13) check("R8 direct afull_n at write edge", afull_n, 0);
      if (i == 2)  begin settle(); check("R5 aempty_n count 2 off 3", aempty_n, 0); end
      if (i == 3)  begin settle(); check("R5 aempty_n count 3 off 3", aempty_n, 1);
                                   check("R2 empty_n with data", empty_n, 1); end
      if (i == 8)  begin settle(); check("R4 half_full at 8", half_full, 0); end
      if (i == 9)  begin settle(); check("R4 half_full at 9", half_full, 1); end
      if (i == 12) begin settle(); check("R6 afull_n free 4 off 3", afull_n, 1); end
      if (i == 13) begin settle(); check("R6 afull_n free 3 off 3", afull_n, 0); end
      if (i == 15) begin settle(); check("R2 full_n at 15", full_n, 1); end
    end
    settle();
    check("R2 full_n at 16", full_n, 0);
    wr_word(16'hDEAD);
    settle();
    check("R3 full_n after write while full", full_n, 0);
  endtask

  task automatic test_drain();
    int bad;
    bad = 0;
    for (int i = 1; i <= 16; i++) begin
      rd_word(got);
      if (got !== 16'hA000 + 16'(i)) begin
        bad++;
        check("R1 read order", got, 16'hA000 + 16'(i));
      end
    end
    check("R1 sixteen words in order", bad, 0);
    settle();
    check("R2 empty_n after drain", empty_n, 0);
    rd_word(got);
    check("R3 rd_data holds on empty read", got, 16'hA010);
    wr_word(16'h1234);
    settle();
    rd_word(got);
    check("R3 no pointer slip after ignored accesses", got, 16'h1234);
  endtask

  // Load empty offset 5 and full offset 2, with stray edges in between.
  task automatic test_serial();
    logic [3:0] ae, af;
    ae = 4'd5; af = 4'd2;
    for (int b = 0; b < 4; b++) send_bit(ae[b], 1'b0);
    for (int b = 0; b < 3; b++) send_bit(1'b1, 1'b1);
    for (int b = 0; b < 4; b++) send_bit(af[b], 1'b0);
    do_prst();
    check("R10 empty_n after prst", empty_n, 0);
    check("R10 rd_data after prst", rd_data, 0);
    for (int i = 1; i <= 14; i++) begin
      wr_word(16'hB000 + 16'(i));
      if (i == 4)  begin settle(); check("R9 aempty_n count 4 off 5", aempty_n, 0); end
      if (i == 5)  begin settle(); check("R9 aempty_n count 5 off 5", aempty_n, 1); end
      if (i == 13) begin settle(); check("R9 afull_n free 3 off 2", afull_n, 1); end
    end
    settle();
    check("R9 afull_n free 2 off 2", afull_n, 0);
    do_prst();
    wr_word(16'hC001);
    wr_word(16'hC002);
    wr_word(16'hC003);
    wr_word(16'hC004);
    settle();
    check("R10 empty offset kept after prst", aempty_n, 0);
    rd_word(got);
    check("R1 first word after prst", got, 16'hC001);
  endtask

  // Preset 0 gives offsets 1/1; registered timing.
  task automatic test_sync_mode();
    do_mrst(3'd0, 1'b1);
    check("R11 rd_data zero after mrst", rd_data, 0);
    check("R11 empty_n after second mrst", empty_n, 0);
    check("R7 aempty_n count 0 off 1", aempty_n, 0);
    wr_word(16'hD001);
    settle();
    check("R7 aempty_n count 1 off 1", aempty_n, 1);
    for (int i = 2; i <= 14; i++) wr_word(16'hD000 + 16'(i));
    settle();
    check("R7 afull_n free 2 off 1", afull_n, 1);
    wr_word(16'hD00F);
    check("R8 registered afull_n lags write edge", afull_n, 1);
    @(posedge wr_clk);
    #1;
    check("R8 registered afull_n one edge later", afull_n, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    mrst = 1; prst = 0; wr_en = 0; rd_en = 0; load_n = 1; shift_en_n = 1;
    shift_din = 0; preset_sel = 3'd2; strap_sync = 0; wr_data = '0;
    repeat (5) @(posedge rd_clk);
    @(negedge wr_clk);
    mrst = 0;
    settle();
    test_reset_state();
    test_fill();
    test_drain();
    test_serial();
    test_sync_mode();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule